// File: doc/BRIEF.md
# GPIO Port with Peripheral Direction Override

This block is a slice of general-purpose I/O that is W pins wide, set up as a byte-wide port by default. Software reaches it through a small register interface. The interface has a data-output register, a direction register and a read-only input register. The input register shows the synchronized state of the pads. On-chip peripherals such as a serial controller or an SPI unit drive a per-pin enable, a direction request and an output value. While a pin's enable is high, the peripheral owns that pin. The software direction bit stays as written, and it takes control again as soon as the enable drops.

A parameter vector fixes how each pin behaves under override, using two bits per pin. The codes are: 0 forces the pin to output, 1 forces it to input, 2 takes the direction from the peripheral's request (for example SPI master or slave), and 3 means no override. The register offsets are 0 for data, 1 for input and 2 for direction. Offset 3 is unused. The pad outputs and the read-data bus are registered.

Software can compare the pin state it reads back with the value it drives. This exposes an output pin that is shorted or overloaded.

Top module: `gpio_ovr_port`

## Requirements
- R1: With no override active, pad_oe bit i is 1 when direction bit i is 1 and 0 when it is 0. pad_oe follows the direction register one clock edge after the register changes.
- R2: Reset clears the data and direction registers. After reset pad_oe is 0 and pad_out is 0, so every pin is an input.
- R3: Reading offset 1 returns the pad input through a two-flop synchronizer, whatever the direction of the pin. A change on pad_in appears on reg_rdata on the third rising edge, with reg_addr held at 1.
- R4: The input register is read-only. A write to offset 1 leaves the data register, the direction register and the pads unchanged.
- R5: Registers at offsets 0 and 2 return the last value written. Read data appears one edge after reg_addr is presented.
- R6: On a pin of kind 0 with its peripheral enable high, pad_oe is 1.
- R7: On a pin of kind 1 with its peripheral enable high, pad_oe is 0.
- R8: On a pin of kind 2 with its peripheral enable high, pad_oe equals that pin's per_dir bit.
- R9: A write to the direction register while an override is active updates the stored value, which can be read back, but does not change pad_oe on overridden pins.
- R10: On the first edge after a peripheral enable drops, pad_oe of that pin returns to the stored direction bit.
- R11: pad_out equals per_out on overridden pins and the data register on all other pins.
- R12: A read of offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Registered read data |
| per_en | input | W | Per-pin peripheral enable |
| per_dir | input | W | Direction request for mode-dependent pins, 1 = output |
| per_out | input | W | Peripheral output value |
| pad_in | input | W | Pad input (asynchronous) |
| pad_oe | output | W | Pad output enable |
| pad_out | output | W | Pad output value |

## Verification
The hardest case to reach is a write to the direction register while an override is active, followed by the override being released. The stored bits must change without the pad moving, and they must then take control on exactly the next edge. A directed sequence handles this. It enables every peripheral, writes the opposite direction pattern and reads it back, then drops the enables and samples pad_oe one edge later. Random rounds of enables, mode requests and writes to every offset, including the read-only and unused ones, then cover the three pin kinds against a bench model.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  // Per-pin override kinds (2-bit code per pin in the kind vector)
  localparam logic [1:0] KIND_OUT  = 2'd0;
  localparam logic [1:0] KIND_IN   = 2'd1;
  localparam logic [1:0] KIND_MODE = 2'd2;
  localparam logic [1:0] KIND_NONE = 2'd3;

  // Register offsets
  localparam int OFS_DATA = 0;
  localparam int OFS_IN   = 1;
  localparam int OFS_DIR  = 2;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr) begin
      if (addr == A_DATA) data_q <= wdata;
      if (addr == A_DIR)  dir_q  <= wdata;
    end
  end
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
  import gpio_ovr_pkg::*;
#(
  parameter int               W        = 8,
  parameter logic [2*W-1:0]   OVR_KIND = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] per_en,
  input  logic [W-1:0] per_dir,
  input  logic [W-1:0] per_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out
);
  logic [W-1:0] oe_d;
  logic [W-1:0] out_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam logic [1:0] KIND = OVR_KIND[2*i +: 2];
    if (KIND == KIND_NONE) begin : g_none
      assign oe_d[i]  = dir_q[i];
      assign out_d[i] = data_q[i];
    end else begin : g_ovr
      logic forced;
      if (KIND == KIND_OUT) begin : g_out
        assign forced = 1'b1;
      end else if (KIND == KIND_IN) begin : g_in
        assign forced = 1'b0;
      end else begin : g_mode
        assign forced = per_dir[i];
      end
      assign oe_d[i]  = per_en[i] ? forced     : dir_q[i];
      assign out_d[i] = per_en[i] ? per_out[i] : data_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= oe_d;
      pad_out <= out_d;
    end
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int             W        = 8,
  parameter int             ADDR_W   = 2,
  parameter logic [2*W-1:0] OVR_KIND = 16'h1844
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      per_en,
  input  logic [W-1:0]      per_dir,
  input  logic [W-1:0]      per_out,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_q;

  gpio_ovr_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .data_q(data_q), .dir_q(dir_q)
  );

  gpio_ovr_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_q)
  );

  gpio_ovr_pinmux #(.W(W), .OVR_KIND(OVR_KIND)) u_mux (
    .clk(clk), .rst(rst), .dir_q(dir_q), .data_q(data_q),
    .per_en(per_en), .per_dir(per_dir), .per_out(per_out),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_DATA:  reg_rdata <= data_q;
        A_IN:    reg_rdata <= pin_q;
        A_DIR:   reg_rdata <= dir_q;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk
  import gpio_ovr_pkg::*;
#(
  parameter int             W        = 8,
  parameter int             ADDR_W   = 2,
  parameter logic [2*W-1:0] OVR_KIND = 16'h1844
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [W-1:0]      reg_rdata,
  input logic [W-1:0]      per_en,
  input logic [W-1:0]      per_dir,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_out
);
  function automatic logic [W-1:0] kind_mask(input logic [1:0] k);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (OVR_KIND[2*i +: 2] == k);
    return m;
  endfunction

  localparam logic [W-1:0] M_OUT  = kind_mask(KIND_OUT);
  localparam logic [W-1:0] M_IN   = kind_mask(KIND_IN);
  localparam logic [W-1:0] M_MODE = kind_mask(KIND_MODE);
  localparam logic [W-1:0] M_OVR  = M_OUT | M_IN | M_MODE;

  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  assert_reset_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0 && pad_out == '0));

  assert_in_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && $past(reg_addr) == ADDR_W'(OFS_IN)) |-> reg_rdata == $past(pad_in, 3));

  assert_forced_out_R6: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2) |-> ((pad_oe & $past(per_en) & M_OUT) == ($past(per_en) & M_OUT)));

  assert_forced_in_R7: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2) |-> ((pad_oe & $past(per_en) & M_IN) == '0));

  assert_mode_dir_R8: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2) |-> (((pad_oe ^ $past(per_dir)) & $past(per_en) & M_MODE) == '0));

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && !$past(reg_wr && reg_addr == ADDR_W'(OFS_DATA), 2)
     && (($past(per_en) | $past(per_en, 2)) & M_OVR) == '0) |-> $stable(pad_out));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W), .ADDR_W(ADDR_W), .OVR_KIND(OVR_KIND)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .per_en(per_en), .per_dir(per_dir), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/gpio_ovr_port_bench.sv
module gpio_ovr_port_bench;
  localparam int             W     = 8;
  localparam int             AW    = 2;
  localparam logic [2*W-1:0] KINDS = 16'h1844;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [W-1:0]  reg_wdata = '0, reg_rdata;
  logic [W-1:0]  per_en = '0, per_dir = '0, per_out = '0, pad_in = '0;
  logic [W-1:0]  pad_oe, pad_out;

  gpio_ovr_port #(.W(W), .ADDR_W(AW), .OVR_KIND(KINDS)) u_gpio_ovr_port (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .per_en(per_en), .per_dir(per_dir), .per_out(per_out),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] dir_m = '0, data_m = '0;

  function automatic logic [W-1:0] exp_oe(input logic [W-1:0] en, input logic [W-1:0] pd,
                                          input logic [W-1:0] dr);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case (KINDS[2*i +: 2])
        2'd0:    r[i] = en[i] ? 1'b1  : dr[i];
        2'd1:    r[i] = en[i] ? 1'b0  : dr[i];
        2'd2:    r[i] = en[i] ? pd[i] : dr[i];
        default: r[i] = dr[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_out(input logic [W-1:0] en, input logic [W-1:0] po,
                                           input logic [W-1:0] dt);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = (en[i] && KINDS[2*i +: 2] != 2'd3) ? po[i] : dt[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pads(input string req);
    @(posedge clk);
    @(negedge clk);
    chk({req, " pad_oe"}, pad_oe, exp_oe(per_en, per_dir, dir_m));
    chk({req, " R11 pad_out"}, pad_out, exp_out(per_en, per_out, data_m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2 pad_oe", pad_oe, '0);
    chk("R2 pad_out", pad_out, '0);
    rd(2'd2, v); chk("R2 dir", v, '0);
    rd(2'd0, v); chk("R2 data", v, '0);

    // R5 and R1: write and read back
    wr(2'd2, 8'hA5); dir_m = 8'hA5;
    rd(2'd2, v); chk("R5 dir readback", v, 8'hA5);
    wr(2'd0, 8'h3C); data_m = 8'h3C;
    rd(2'd0, v); chk("R5 data readback", v, 8'h3C);
    pads("R1");

    // R4: write to input offset is ignored
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R4 data untouched", v, 8'h3C);
    rd(2'd2, v); chk("R4 dir untouched", v, 8'hA5);
    pads("R4");

    // R12: unused offset
    rd(2'd3, v); chk("R12 unused offset", v, '0);

    // R3: exact synchronizer latency, pin state differs from driven data
    @(negedge clk);
    pad_in = 8'h0F; reg_addr = 2'd1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R3 settled", reg_rdata, 8'h0F);
    pad_in = 8'hF0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R3 two edges old", reg_rdata, 8'h0F);
    @(posedge clk);
    @(negedge clk);
    chk("R3 third edge new", reg_rdata, 8'hF0);

    // R6 R7 R8 R9 R10: override while direction written
    wr(2'd2, 8'h00); dir_m = 8'h00;
    @(negedge clk);
    per_en = 8'hFF; per_dir = 8'h20; per_out = 8'h99;
    pads("R6 R7 R8");
    wr(2'd2, 8'hFF); dir_m = 8'hFF;
    rd(2'd2, v); chk("R9 dir stored", v, 8'hFF);
    chk("R9 pad_oe unaffected", pad_oe, exp_oe(8'hFF, 8'h20, 8'h00));
    @(negedge clk);
    per_en = 8'h00;
    @(posedge clk);
    @(negedge clk);
    chk("R10 release", pad_oe, 8'hFF);
    chk("R10 R11 release out", pad_out, 8'h3C);

    // R8: mode pin follows request against stored direction
    @(negedge clk);
    per_en = 8'h20; per_dir = 8'h00;
    pads("R8");
    @(negedge clk);
    per_dir = 8'h20;
    pads("R8");

    // Random rounds covering R1 R5 R6 R7 R8 R11 R12
    void'($urandom(32'h5EED1234));
    for (int n = 0; n < 300; n++) begin
      int op, r;
      @(negedge clk);
      per_en = W'($urandom); per_dir = W'($urandom); per_out = W'($urandom);
      pad_in = W'($urandom);
      op = int'($urandom % 5);
      if (op < 4) begin
        reg_wr = 1'b1; reg_addr = AW'(op); reg_wdata = W'($urandom);
        if (op == 0) data_m = reg_wdata;
        if (op == 2) dir_m = reg_wdata;
      end
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      r = int'($urandom % 3);
      reg_addr = (r == 0) ? 2'd0 : (r == 1) ? 2'd2 : 2'd3;
      @(posedge clk);
      @(negedge clk);
      chk("R1 R6 R7 R8 random pad_oe", pad_oe, exp_oe(per_en, per_dir, dir_m));
      chk("R11 random pad_out", pad_out, exp_out(per_en, per_out, data_m));
      chk("R5 R12 random read", reg_rdata,
          (r == 0) ? data_m : (r == 1) ? dir_m : '0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule